// File: doc/BRIEF.md
# Three-Lane Tempo Subdivider

This block takes a tempo clock that arrives as a level signal, typically 24 pulses per beat, and produces three divided pulse trains from it at the same time. The lanes correspond to eighth notes (one pulse per 12 input pulses), eighth-note triplets (one per 8) and sixteenth notes (one per 6). Every low-to-high transition of the input, sampled in the system clock domain, counts as one input pulse. The input may be a square clock or a bipolar waveform whose sign bit has been taken upstream.

A single modulo-24 phase counter is shared by all three lanes. Each lane compares the counter phase against its own ratio when an input edge arrives, so the lanes can never drift apart. All three fire together on the first input pulse after reset and again on every 24th pulse after it. Each output is a one-system-cycle strobe. The input and outputs are plain control strobes with no handshake, because a tempo pulse cannot be held back. A consumer that misses a strobe simply loses that subdivision tick.

Top module: `tempo_subdivider`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all three outputs are 0. Reset also returns the phase to pulse index 0.
- R2: An input pulse is counted when `tick_in` is sampled high and the sample one clock earlier was low. The earlier-sample register resets to high, so a level that is already high when reset is released is not counted.
- R3: `strobe_eighth` pulses for input pulse k (0-based since reset) exactly when k mod 12 = 0, which gives 2 strobes per 24 input pulses.
- R4: `strobe_triplet` pulses for input pulse k exactly when k mod 8 = 0, which gives 3 strobes per 24 input pulses.
- R5: `strobe_sixteenth` pulses for input pulse k exactly when k mod 6 = 0, which gives 4 strobes per 24 input pulses.
- R6: Each strobe is high for exactly one system clock cycle. That cycle follows the clock edge at which the input edge was first sampled.
- R7: On input pulse 0 and on every pulse whose index is a multiple of 24, all three lanes fire in the same cycle. Every eighth strobe coincides with a sixteenth strobe.
- R8: No strobe appears without a counted input edge. A level held high or low for any time produces none.
- R9: The phase counter stays below 24. It wraps from 23 to 0 on the next edge and changes only on counted edges. Asserting reset in the middle of a sequence restarts the phase at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Incoming tempo pulse level |
| strobe_eighth | output | 1 | One-cycle strobe, input divided by 12 |
| strobe_triplet | output | 1 | One-cycle strobe, input divided by 8 |
| strobe_sixteenth | output | 1 | One-cycle strobe, input divided by 6 |

## Verification
On every cycle, the assertions check the following:
- the phase stays inside its 24-step range and moves only on an edge;
- each strobe is one cycle wide and is always preceded by a detected edge;
- the eighth lane never fires without the sixteenth lane;
- reset silences the outputs.

Which input pulse each lane selects is left to the bench's scenarios, since it depends on the pulse history since reset. These scenarios are long pulse trains with varied spacing, a level held high across reset, a reset in the middle of a sequence, and long idle levels.

// File: rtl/tempo_pkg.sv
package tempo_pkg;
  typedef enum logic [1:0] {
    LANE_EIGHTH    = 2'd0,
    LANE_TRIPLET   = 2'd1,
    LANE_SIXTEENTH = 2'd2
  } lane_e;

  localparam int NUM_LANES = 3;

  function automatic int phase_width(input int base);
    return (base <= 2) ? 1 : $clog2(base);
  endfunction
endpackage

// File: rtl/tempo_edge_detect.sv
module tempo_edge_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  // Resets high so a level already high at release is not an edge (R2)
  always_ff @(posedge clk_i) begin
    if (rst_i) level_q <= 1'b1;
    else       level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // R2: two consecutive samples cannot both be rising transitions
  p_no_double_rise_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tempo_phase_counter.sv
module tempo_phase_counter #(
  parameter int BASE = 24,
  localparam int CW  = tempo_pkg::phase_width(BASE)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          step_i,
  output logic [CW-1:0] phase_o
);
  localparam logic [CW-1:0] LAST = CW'(BASE - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i)            phase_o <= '0;
    else if (step_i) begin
      if (phase_o == LAST) phase_o <= '0;
      else                 phase_o <= phase_o + 1'b1;
    end
  end

  p_phase_range_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    32'(phase_o) < BASE);
  p_phase_wrap_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && phase_o == LAST) |=> phase_o == '0);
  p_phase_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(phase_o));
endmodule

// File: rtl/tempo_lane_tap.sv
module tempo_lane_tap #(
  parameter int BASE  = 24,
  parameter int RATIO = 12,
  localparam int CW   = tempo_pkg::phase_width(BASE)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          step_i,
  input  logic [CW-1:0] phase_i,
  output logic          strobe_o
);
  logic on_grid;
  assign on_grid = (32'(phase_i) % RATIO) == 0;

  always_ff @(posedge clk_i) begin
    if (rst_i) strobe_o <= 1'b0;
    else       strobe_o <= step_i & on_grid;
  end

  // R6: strobe lasts one cycle
  p_one_cycle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_o |=> !strobe_o);
  // R8: a strobe always follows a counted edge
  p_needs_edge_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_o |-> $past(step_i));
endmodule

// File: rtl/tempo_subdivider.sv
module tempo_subdivider #(
  parameter int BASE_DIV      = 24,
  parameter int DIV_EIGHTH    = 12,
  parameter int DIV_TRIPLET   = 8,
  parameter int DIV_SIXTEENTH = 6,
  localparam int CW = tempo_pkg::phase_width(BASE_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic strobe_eighth,
  output logic strobe_triplet,
  output logic strobe_sixteenth
);
  import tempo_pkg::*;

  logic                 rise;
  logic [CW-1:0]        phase;
  logic [NUM_LANES-1:0] strobes;

  tempo_edge_detect u_edge (
    .clk_i   (clk),
    .rst_i   (rst),
    .level_i (tick_in),
    .rise_o  (rise)
  );

  tempo_phase_counter #(.BASE(BASE_DIV)) u_phase (
    .clk_i   (clk),
    .rst_i   (rst),
    .step_i  (rise),
    .phase_o (phase)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int R = (i == int'(LANE_EIGHTH))  ? DIV_EIGHTH :
                       (i == int'(LANE_TRIPLET)) ? DIV_TRIPLET : DIV_SIXTEENTH;
    tempo_lane_tap #(.BASE(BASE_DIV), .RATIO(R)) u_tap (
      .clk_i    (clk),
      .rst_i    (rst),
      .step_i   (rise),
      .phase_i  (phase),
      .strobe_o (strobes[i])
    );
  end

  assign strobe_eighth    = strobes[LANE_EIGHTH];
  assign strobe_triplet   = strobes[LANE_TRIPLET];
  assign strobe_sixteenth = strobes[LANE_SIXTEENTH];

  // R1: reset silences every lane on the following cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (strobes == '0));

  if (DIV_EIGHTH % DIV_SIXTEENTH == 0) begin : g_align_chk
    // R7: eighth ticks sit on the sixteenth grid
    p_eighth_aligned_r7: assert property (@(posedge clk) disable iff (rst)
      strobe_eighth |-> strobe_sixteenth);
  end
endmodule

// File: tb/tempo_subdivider_tb.sv
module tempo_subdivider_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_in = 1'b0;
  logic s8, st, s16;
  int   n_tests = 0;
  int   n_fail  = 0;
  int   k = 0;     // pulse index expected since reset
  bit   done = 0;

  always #5 clk = ~clk;

  tempo_subdivider u_dut (
    .clk (clk), .rst (rst), .tick_in (tick_in),
    .strobe_eighth (s8), .strobe_triplet (st), .strobe_sixteenth (s16)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (pulse %0d)", req, got, exp, k);
    end
  endtask

  task automatic do_reset(input bit level);
    @(negedge clk); rst = 1'b1; tick_in = level;
    repeat (3) @(negedge clk);
    chk({s8, st, s16} == 3'b000, "R1 during reset", {s8, st, s16}, 0);
    rst = 1'b0; k = 0;
    @(negedge clk);
    chk({s8, st, s16} == 3'b000, "R1 after release", {s8, st, s16}, 0);
  endtask

  // one input pulse: hi cycles high, lo cycles low
  task automatic pulse(input int hi, input int lo);
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk);
    chk(s8  == (k % 12 == 0), "R3 eighth lane",    s8,  int'(k % 12 == 0));
    chk(st  == (k % 8  == 0), "R4 triplet lane",   st,  int'(k % 8 == 0));
    chk(s16 == (k % 6  == 0), "R5 sixteenth lane", s16, int'(k % 6 == 0));
    if (k % 24 == 0)
      chk({s8, st, s16} == 3'b111, "R7 all lanes aligned", {s8, st, s16}, 7);
    @(negedge clk);
    chk({s8, st, s16} == 3'b000, "R6 single-cycle strobe", {s8, st, s16}, 0);
    for (int i = 2; i < hi; i++) @(negedge clk);
    tick_in = 1'b0;
    for (int i = 1; i < lo; i++) @(negedge clk);
    k++;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
  endtask

  task automatic t_steady_train();
    for (int i = 0; i < 48; i++) pulse(2, 2);
  endtask

  task automatic t_varied_spacing();
    for (int i = 0; i < 30; i++) pulse(1 + (i % 4), 1 + (i % 3));
  endtask

  task automatic t_high_at_reset();
    bit seen = 0;
    do_reset(1'b1);                     // R2: held-high level is no edge
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (s8 | st | s16) seen = 1;
    end
    chk(!seen, "R2 level high across reset not counted", seen, 0);
    tick_in = 1'b0; @(negedge clk);
    pulse(2, 2);                        // must be pulse 0: all lanes
  endtask

  task automatic t_idle_levels();
    bit seen = 0;
    pulse(40, 2);                       // long high after edge
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (s8 | st | s16) seen = 1;
    end
    chk(!seen, "R8 no strobe while idle", seen, 0);
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 7; i++) pulse(2, 3);
    do_reset(1'b0);                     // R9: phase restarts at 0
    for (int i = 0; i < 25; i++) pulse(2, 2);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    t_steady_train();
    t_varied_spacing();
    t_high_at_reset();
    t_idle_levels();
    t_mid_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule